// File: doc/BRIEF.md
# Dual-Port Circular Buffer Address Generator

This block produces up to two data memory addresses in the same clock cycle, so that a processing core can fetch two operands at once. It holds four circular-buffer register sets. Each set has a 32-bit index (the current position), a 32-bit modify (a signed step), a 32-bit length and a 32-bit base. Base and length mark out a buffer, and the index walks through it. Beside the sets sits a file of eight 32-bit pointer registers for plain stack-style addressing.

Each of the two request ports picks a register set or pointer and an operation. The address for a request appears on the port's output in the same cycle. A post-modify request returns the current index and moves that index by its step. The step wraps back into the buffer whenever it leaves it. A single write port and a combinational read port give access to every register. When the write port and a request port target the same index in the same cycle, the request port wins and the lost write is flagged.

Top module: `dual_circ_agen`

## Requirements
- R1: After a synchronous reset, every index, modify, length, base and pointer register reads back as zero.
- R2: Register address encoding. Bit 4 set selects pointer `addr[2:0]`. Bit 4 clear selects set `addr[1:0]`, with kind `addr[3:2]`: 0 is index, 1 is modify, 2 is length, 3 is base. A write lands on the next clock edge. The read port returns the selected register combinationally.
- R3: Operation encoding: 0 is idle, 1 is peek, 2 is post-modify, 3 is pointer. A post-modify request outputs the current index of set `sel[1:0]` in the same cycle. If the new position stays inside [base, base+length), the index becomes index+modify at the next edge.
- R4: On a post-modify, if index+modify is at or above base+length (unsigned), the index becomes index+modify-length.
- R5: On a post-modify, if index+modify is below base, the index becomes index+modify+length.
- R6: When length is zero, a post-modify updates the index to index+modify, with no wrap in either direction.
- R7: A peek request outputs the current index of set `sel[1:0]` and leaves it unchanged.
- R8: A pointer request outputs pointer register `sel[2:0]`. Pointer registers change only through the write port.
- R9: The valid output of a port is high exactly when its operation is not idle. The two ports act independently in one cycle when they name different sets.
- R10: When both ports post-modify the same set in one cycle, port 1 outputs the old index. Only port 0's update is applied.
- R11: A write to an index register that a port post-modifies in the same cycle is discarded. The port update is kept, and the dropped flag is high for the following cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 5 | Register write address (R2 encoding) |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read address (R2 encoding) |
| rd_data | output | 32 | Register read data, combinational |
| p0_op | input | 2 | Port 0 operation |
| p0_sel | input | 3 | Port 0 set or pointer select |
| p1_op | input | 2 | Port 1 operation |
| p1_sel | input | 3 | Port 1 set or pointer select |
| p0_addr | output | 32 | Port 0 address |
| p0_vld | output | 1 | Port 0 address valid |
| p1_addr | output | 32 | Port 1 address |
| p1_vld | output | 1 | Port 1 address valid |
| wr_dropped | output | 1 | Previous cycle's index write was discarded |

## Verification
The wrap assertion assumes three things about the inputs. Base plus length must not overflow 32 bits. The step magnitude must not exceed the length. The index must start inside its buffer. The assertion only fires when the previous cycle met all three. The stimulus keeps to these limits. Bases are drawn below 2^28 and lengths are at most 40. Modify values are drawn within plus or minus the length. Random index writes land inside the current buffer. Zero-length sets take small arbitrary steps, because no wrap rule applies to them.

// File: rtl/agen_pkg.sv
package agen_pkg;

    localparam int unsigned AW     = 32;
    localparam int unsigned NSETS  = 4;
    localparam int unsigned NPTR   = 8;
    localparam int unsigned SET_W  = $clog2(NSETS);
    localparam int unsigned PTR_W  = $clog2(NPTR);
    localparam int unsigned KIND_W = 2;
    localparam int unsigned REG_AW = 1 + (((SET_W + KIND_W) > PTR_W) ? (SET_W + KIND_W) : PTR_W);

    typedef logic [AW-1:0] word_t;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_PEEK    = 2'd1,
        OP_POSTMOD = 2'd2,
        OP_PTR     = 2'd3
    } agen_op_e;

    typedef enum logic [KIND_W-1:0] {
        RK_INDEX  = 2'd0,
        RK_MODIFY = 2'd1,
        RK_LENGTH = 2'd2,
        RK_BASE   = 2'd3
    } reg_kind_e;

    typedef struct packed {
        agen_op_e         op;
        logic [PTR_W-1:0] sel;
    } agen_req_t;

    typedef struct packed {
        logic             is_ptr;
        reg_kind_e        kind;
        logic [PTR_W-1:0] slot;
    } reg_sel_t;

    // Split a register address into pointer flag, kind and slot.
    function automatic reg_sel_t decode_reg(input logic [REG_AW-1:0] a);
        reg_sel_t d;
        d.is_ptr = a[REG_AW-1];
        d.kind   = reg_kind_e'(a[SET_W +: KIND_W]);
        d.slot   = a[PTR_W-1:0];
        return d;
    endfunction

    // Post-modify step with circular wrap; zero length means linear.
    function automatic word_t circ_next(input word_t idx, input word_t mod,
                                        input word_t len, input word_t base);
        word_t sum;
        word_t top;
        sum = idx + mod;
        top = base + len;
        if (len != '0) begin
            if (sum >= top)
                sum = sum - len;
            else if (sum < base)
                sum = sum + len;
        end
        return sum;
    endfunction

    function automatic logic in_buf(input word_t idx, input word_t len, input word_t base);
        return (idx >= base) && ((idx - base) < len);
    endfunction

    function automatic logic mod_within(input word_t mod, input word_t len);
        word_t mag;
        mag = mod[AW-1] ? (~mod + 1'b1) : mod;
        return mag <= len;
    endfunction

endpackage

// File: rtl/agen_port.sv
module agen_port
    import agen_pkg::*;
(
    input  agen_req_t                  req,
    input  word_t     [NSETS-1:0]      idx_v,
    input  word_t     [NSETS-1:0]      mod_v,
    input  word_t     [NSETS-1:0]      len_v,
    input  word_t     [NSETS-1:0]      base_v,
    input  word_t     [NPTR-1:0]       ptr_v,
    output word_t                      addr,
    output logic                       vld,
    output logic                       upd_en,
    output logic      [SET_W-1:0]      upd_set,
    output word_t                      upd_val
);

    logic [SET_W-1:0] set_sel;
    assign set_sel = req.sel[SET_W-1:0];

    always_comb begin
        addr   = '0;
        vld    = 1'b0;
        upd_en = 1'b0;
        case (req.op)
            OP_PEEK: begin
                addr = idx_v[set_sel];
                vld  = 1'b1;
            end
            OP_POSTMOD: begin
                addr   = idx_v[set_sel];
                vld    = 1'b1;
                upd_en = 1'b1;
            end
            OP_PTR: begin
                addr = ptr_v[req.sel];
                vld  = 1'b1;
            end
            default: ;
        endcase
    end

    assign upd_set = set_sel;
    assign upd_val = circ_next(idx_v[set_sel], mod_v[set_sel], len_v[set_sel], base_v[set_sel]);

endmodule

// File: rtl/agen_regs.sv
module agen_regs
    import agen_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic     [REG_AW-1:0]   wr_addr,
    input  word_t                   wr_data,
    input  logic     [REG_AW-1:0]   rd_addr,
    output word_t                   rd_data,
    input  logic                    upd0_en,
    input  logic     [SET_W-1:0]    upd0_set,
    input  word_t                   upd0_val,
    input  logic                    upd1_en,
    input  logic     [SET_W-1:0]    upd1_set,
    input  word_t                   upd1_val,
    output word_t    [NSETS-1:0]    idx_q,
    output word_t    [NSETS-1:0]    mod_q,
    output word_t    [NSETS-1:0]    len_q,
    output word_t    [NSETS-1:0]    base_q,
    output word_t    [NPTR-1:0]     ptr_q,
    output logic                    wr_dropped
);

    reg_sel_t         wsel;
    reg_sel_t         rsel;
    logic [NSETS-1:0] take0;
    logic [NSETS-1:0] take1;
    logic [NSETS-1:0] wr_set;
    logic [NSETS-1:0] wr_idx;
    logic [NPTR-1:0]  wr_ptr;
    logic             collide;

    assign wsel = decode_reg(wr_addr);
    assign rsel = decode_reg(rd_addr);

    genvar gs;
    generate
        for (gs = 0; gs < NSETS; gs++) begin : g_set_ctl
            assign take0[gs]  = upd0_en && (upd0_set == SET_W'(gs));
            assign take1[gs]  = upd1_en && (upd1_set == SET_W'(gs)) && !take0[gs];
            assign wr_set[gs] = wr_en && !wsel.is_ptr && (wsel.slot[SET_W-1:0] == SET_W'(gs));
            assign wr_idx[gs] = wr_set[gs] && (wsel.kind == RK_INDEX);
        end
    endgenerate

    genvar gp;
    generate
        for (gp = 0; gp < NPTR; gp++) begin : g_ptr_ctl
            assign wr_ptr[gp] = wr_en && wsel.is_ptr && (wsel.slot == PTR_W'(gp));
        end
    endgenerate

    assign collide = |(wr_idx & (take0 | take1));

    // Index: port 0 update, then port 1 update, then the write port.
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            mod_q  <= '0;
            len_q  <= '0;
            base_q <= '0;
        end else begin
            for (int s = 0; s < NSETS; s++) begin
                if (take0[s])
                    idx_q[s] <= upd0_val;
                else if (take1[s])
                    idx_q[s] <= upd1_val;
                else if (wr_idx[s])
                    idx_q[s] <= wr_data;
                if (wr_set[s] && (wsel.kind == RK_MODIFY)) mod_q[s]  <= wr_data;
                if (wr_set[s] && (wsel.kind == RK_LENGTH)) len_q[s]  <= wr_data;
                if (wr_set[s] && (wsel.kind == RK_BASE))   base_q[s] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            for (int p = 0; p < NPTR; p++)
                if (wr_ptr[p]) ptr_q[p] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) wr_dropped <= 1'b0;
        else     wr_dropped <= collide;
    end

    always_comb begin
        if (rsel.is_ptr) begin
            rd_data = ptr_q[rsel.slot];
        end else begin
            case (rsel.kind)
                RK_INDEX:  rd_data = idx_q[rsel.slot[SET_W-1:0]];
                RK_MODIFY: rd_data = mod_q[rsel.slot[SET_W-1:0]];
                RK_LENGTH: rd_data = len_q[rsel.slot[SET_W-1:0]];
                default:   rd_data = base_q[rsel.slot[SET_W-1:0]];
            endcase
        end
    end

    generate
        for (gs = 0; gs < NSETS; gs++) begin : g_set_chk
            AST_RESET_CLEARS_SET: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> (idx_q[gs] == '0 && mod_q[gs] == '0 && len_q[gs] == '0 && base_q[gs] == '0)); // R1

            AST_ZERO_LEN_LINEAR: assert property (@(posedge clk) disable iff (rst)
                $past(!rst && take0[gs] && len_q[gs] == '0) |-> (idx_q[gs] == $past(idx_q[gs] + mod_q[gs]))); // R6

            AST_WRAP_STAYS_IN_BUF: assert property (@(posedge clk) disable iff (rst)
                $past(!rst && (take0[gs] || take1[gs]) && len_q[gs] != '0
                      && in_buf(idx_q[gs], len_q[gs], base_q[gs])
                      && mod_within(mod_q[gs], len_q[gs]))
                |-> in_buf(idx_q[gs], $past(len_q[gs]), $past(base_q[gs]))); // R4

            AST_PORT0_WINS: assert property (@(posedge clk) disable iff (rst)
                $past(!rst && upd0_en && upd1_en && upd0_set == upd1_set && upd0_set == SET_W'(gs))
                |-> (idx_q[gs] == $past(upd0_val))); // R10
        end
    endgenerate

    AST_DROP_FLAG_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (wr_dropped == $past(collide))); // R11

    AST_PTR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !(wr_en && wsel.is_ptr)) |-> $stable(ptr_q)); // R8

    AST_RESET_CLEARS_PTR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ptr_q == '0)); // R1

    generate
        for (gp = 0; gp < NPTR; gp++) begin : g_ptr_chk
            AST_PTR_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
                $past(!rst && wr_ptr[gp]) |-> (ptr_q[gp] == $past(wr_data))); // R2
        end
    endgenerate

endmodule

// File: rtl/dual_circ_agen.sv
module dual_circ_agen
    import agen_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [4:0]         wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [4:0]         rd_addr,
    output logic [31:0]        rd_data,
    input  logic [1:0]         p0_op,
    input  logic [2:0]         p0_sel,
    input  logic [1:0]         p1_op,
    input  logic [2:0]         p1_sel,
    output logic [31:0]        p0_addr,
    output logic               p0_vld,
    output logic [31:0]        p1_addr,
    output logic               p1_vld,
    output logic               wr_dropped
);

    localparam int unsigned NPORTS = 2;

    word_t     [NSETS-1:0]  idx_q, mod_q, len_q, base_q;
    word_t     [NPTR-1:0]   ptr_q;
    agen_req_t [NPORTS-1:0] req;
    word_t     [NPORTS-1:0] addr;
    logic      [NPORTS-1:0] vld;
    logic      [NPORTS-1:0] upd_en;
    logic      [NPORTS-1:0][SET_W-1:0] upd_set;
    word_t     [NPORTS-1:0] upd_val;

    assign req[0] = '{op: agen_op_e'(p0_op), sel: p0_sel};
    assign req[1] = '{op: agen_op_e'(p1_op), sel: p1_sel};

    genvar gi;
    generate
        for (gi = 0; gi < NPORTS; gi++) begin : g_port
            agen_port u_port (
                .req     (req[gi]),
                .idx_v   (idx_q),
                .mod_v   (mod_q),
                .len_v   (len_q),
                .base_v  (base_q),
                .ptr_v   (ptr_q),
                .addr    (addr[gi]),
                .vld     (vld[gi]),
                .upd_en  (upd_en[gi]),
                .upd_set (upd_set[gi]),
                .upd_val (upd_val[gi])
            );
        end
    endgenerate

    agen_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .upd0_en    (upd_en[0]),
        .upd0_set   (upd_set[0]),
        .upd0_val   (upd_val[0]),
        .upd1_en    (upd_en[1]),
        .upd1_set   (upd_set[1]),
        .upd1_val   (upd_val[1]),
        .idx_q      (idx_q),
        .mod_q      (mod_q),
        .len_q      (len_q),
        .base_q     (base_q),
        .ptr_q      (ptr_q),
        .wr_dropped (wr_dropped)
    );

    assign p0_addr = addr[0];
    assign p0_vld  = vld[0];
    assign p1_addr = addr[1];
    assign p1_vld  = vld[1];

    AST_SHARED_SET_SAME_ADDR: assert property (@(posedge clk) disable iff (rst)
        (upd_en[0] && upd_en[1] && upd_set[0] == upd_set[1]) |-> (p1_addr == p0_addr)); // R10

endmodule

// File: tb/sim_dual_circ_agen.sv
module sim_dual_circ_agen;
    import agen_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [4:0]  wr_addr, rd_addr;
    logic [31:0] wr_data, rd_data;
    logic [1:0]  p0_op, p1_op;
    logic [2:0]  p0_sel, p1_sel;
    logic [31:0] p0_addr, p1_addr;
    logic        p0_vld, p1_vld, wr_dropped;

    always #2 clk = ~clk;

    dual_circ_agen u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .p0_op(p0_op), .p0_sel(p0_sel),
        .p1_op(p1_op), .p1_sel(p1_sel), .p0_addr(p0_addr), .p0_vld(p0_vld),
        .p1_addr(p1_addr), .p1_vld(p1_vld), .wr_dropped(wr_dropped)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    word_t mi [4];
    word_t mm [4];
    word_t ml [4];
    word_t mb [4];
    word_t mp [8];
    logic  exp_drop;

    function automatic word_t ref_next(input word_t i, input word_t m, input word_t l, input word_t b);
        word_t s;
        s = i + m;
        if (l != 0) begin
            if (s >= b + l)  s = s - l;
            else if (s < b)  s = s + l;
        end
        return s;
    endfunction

    function automatic word_t ref_read(input logic [4:0] a);
        if (a[4]) return mp[a[2:0]];
        case (a[3:2])
            2'd0:    return mi[a[1:0]];
            2'd1:    return mm[a[1:0]];
            2'd2:    return ml[a[1:0]];
            default: return mb[a[1:0]];
        endcase
    endfunction

    task automatic chk(input string tag, input word_t act, input word_t exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic port_chk(input int pn, input agen_op_e o, input logic [2:0] s,
                            input logic conflict, input word_t a, input logic v);
        chk($sformatf("R9 port%0d valid", pn), {31'b0, v}, {31'b0, o != OP_IDLE});
        case (o)
            OP_PEEK:    chk($sformatf("R7 port%0d peek", pn), a, mi[s[1:0]]);
            OP_POSTMOD: chk(conflict ? "R10 port1 old index" : $sformatf("R3 port%0d postmod", pn), a, mi[s[1:0]]);
            OP_PTR:     chk($sformatf("R8 port%0d pointer", pn), a, mp[s]);
            default: ;
        endcase
    endtask

    task automatic step(input agen_op_e o0, input logic [2:0] s0, input agen_op_e o1,
                        input logic [2:0] s1, input logic we, input logic [4:0] wa,
                        input word_t wd, input logic [4:0] ra);
        word_t ni [4];
        logic  d;
        logic  conflict;
        @(negedge clk);
        p0_op = o0; p0_sel = s0; p1_op = o1; p1_sel = s1;
        wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
        #1;
        conflict = (o0 == OP_POSTMOD) && (o1 == OP_POSTMOD) && (s0[1:0] == s1[1:0]);
        port_chk(0, o0, s0, 1'b0, p0_addr, p0_vld);
        port_chk(1, o1, s1, conflict, p1_addr, p1_vld);
        chk("R2 read port", rd_data, ref_read(ra));
        chk("R11 drop flag", {31'b0, wr_dropped}, {31'b0, exp_drop});
        @(posedge clk);
        ni = mi;
        d  = 1'b0;
        if (o0 == OP_POSTMOD)
            ni[s0[1:0]] = ref_next(mi[s0[1:0]], mm[s0[1:0]], ml[s0[1:0]], mb[s0[1:0]]);
        if (o1 == OP_POSTMOD && !conflict)
            ni[s1[1:0]] = ref_next(mi[s1[1:0]], mm[s1[1:0]], ml[s1[1:0]], mb[s1[1:0]]);
        if (we) begin
            if (wa[4]) mp[wa[2:0]] = wd;
            else case (wa[3:2])
                2'd0: begin
                    if ((o0 == OP_POSTMOD && s0[1:0] == wa[1:0]) || (o1 == OP_POSTMOD && s1[1:0] == wa[1:0]))
                        d = 1'b1;
                    else
                        ni[wa[1:0]] = wd;
                end
                2'd1:    mm[wa[1:0]] = wd;
                2'd2:    ml[wa[1:0]] = wd;
                default: mb[wa[1:0]] = wd;
            endcase
        end
        mi = ni;
        exp_drop = d;
    endtask

    task automatic wreg(input logic [4:0] a, input word_t d);
        step(OP_IDLE, 3'd0, OP_IDLE, 3'd0, 1'b1, a, d, 5'd0);
    endtask

    task automatic expect_reg(input string tag, input logic [4:0] a, input word_t exp);
        @(negedge clk);
        p0_op = OP_IDLE; p1_op = OP_IDLE; wr_en = 1'b0; rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
        @(posedge clk);
        exp_drop = 1'b0;
    endtask

    task automatic setup_set(input logic [1:0] s, input word_t b, input word_t l,
                             input word_t i, input word_t m);
        wreg({3'b011, s}, b);
        wreg({3'b010, s}, l);
        wreg({3'b000, s}, i);
        wreg({3'b001, s}, m);
    endtask

    function automatic word_t rand_mod(input word_t l);
        int unsigned span;
        span = (l == 0) ? 16 : l;
        return word_t'($urandom_range(0, 2 * span)) - span;
    endfunction

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        p0_op = OP_IDLE; p0_sel = '0; p1_op = OP_IDLE; p1_sel = '0;
        for (int k = 0; k < 4; k++) begin mi[k] = 0; mm[k] = 0; ml[k] = 0; mb[k] = 0; end
        for (int k = 0; k < 8; k++) mp[k] = 0;
        exp_drop = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: every register reads zero after reset
        for (int a = 0; a < 24; a++) expect_reg("R1 reset value", 5'(a), 32'h0);

        // R2: write then read back, including pointers
        wreg(5'h13, 32'hDEAD_BEEF);
        expect_reg("R2 pointer write", 5'h13, 32'hDEAD_BEEF);

        // R4: upper wrap
        setup_set(2'd0, 32'h100, 32'd16, 32'h10C, 32'd6);
        step(OP_POSTMOD, 3'd0, OP_IDLE, 3'd0, 1'b0, 5'd0, 32'd0, 5'd0);
        expect_reg("R4 upper wrap", 5'h00, 32'h102);

        // R5: lower wrap
        setup_set(2'd1, 32'h200, 32'd8, 32'h201, 32'hFFFF_FFFD);
        step(OP_IDLE, 3'd0, OP_POSTMOD, 3'd1, 1'b0, 5'd0, 32'd0, 5'd1);
        expect_reg("R5 lower wrap", 5'h01, 32'h206);

        // R6: zero length is linear both ways
        setup_set(2'd2, 32'h300, 32'd0, 32'h5000, 32'h40);
        step(OP_POSTMOD, 3'd2, OP_IDLE, 3'd0, 1'b0, 5'd0, 32'd0, 5'd2);
        expect_reg("R6 linear up", 5'h02, 32'h5040);
        setup_set(2'd2, 32'h300, 32'd0, 32'h10, 32'hFFFF_FFE0);
        step(OP_POSTMOD, 3'd2, OP_IDLE, 3'd0, 1'b0, 5'd0, 32'd0, 5'd2);
        expect_reg("R6 linear down", 5'h02, 32'hFFFF_FFF0);

        // R7: peek leaves index
        step(OP_PEEK, 3'd0, OP_PEEK, 3'd4, 1'b0, 5'd0, 32'd0, 5'd0);
        expect_reg("R7 peek no update", 5'h00, 32'h102);

        // R10: both ports post-modify set 0
        step(OP_POSTMOD, 3'd0, OP_POSTMOD, 3'd4, 1'b0, 5'd0, 32'd0, 5'd0);
        expect_reg("R10 port0 only", 5'h00, 32'h108);

        // R9: independent sets in one cycle
        step(OP_POSTMOD, 3'd0, OP_POSTMOD, 3'd1, 1'b0, 5'd0, 32'd0, 5'd0);
        expect_reg("R9 set0 moved", 5'h00, 32'h10E);
        expect_reg("R9 set1 moved", 5'h01, 32'h203);

        // R11: index write collides with a port update
        step(OP_POSTMOD, 3'd0, OP_IDLE, 3'd0, 1'b1, 5'h00, 32'hABC, 5'd0);
        @(negedge clk); p0_op = OP_IDLE; wr_en = 1'b0; rd_addr = 5'h00; #1;
        chk("R11 flag raised", {31'b0, wr_dropped}, 32'd1);
        chk("R11 port update kept", rd_data, 32'h104);
        @(posedge clk); exp_drop = 1'b0;
        expect_reg("R11 flag single cycle", 5'h00, 32'h104);
        chk("R11 flag cleared", {31'b0, wr_dropped}, 32'd0);

        // R8: pointer readout, unaffected by post-modify traffic
        step(OP_PTR, 3'd3, OP_POSTMOD, 3'd1, 1'b0, 5'd0, 32'd0, 5'h13);
        expect_reg("R8 pointer unchanged", 5'h13, 32'hDEAD_BEEF);

        // random phase
        for (int k = 0; k < 4; k++) begin
            word_t b, l;
            b = $urandom & 32'h0FFF_FFF0;
            l = (k == 3) ? 0 : $urandom_range(1, 40);
            setup_set(2'(k), b, l, (l == 0) ? b : b + ($urandom % l), rand_mod(l));
        end
        for (int c = 0; c < 4000; c++) begin
            logic        we;
            logic [4:0]  wa;
            word_t       wd;
            logic [1:0]  ws;
            we = ($urandom_range(0, 3) == 0);
            ws = 2'($urandom_range(0, 3));
            case ($urandom_range(0, 2))
                0: begin
                    wa = {3'b000, ws};
                    wd = (ml[ws] == 0) ? $urandom : mb[ws] + ($urandom % ml[ws]);
                end
                1: begin
                    wa = {3'b001, ws};
                    wd = rand_mod(ml[ws]);
                end
                default: begin
                    wa = {2'b10, 3'($urandom_range(0, 7))};
                    wd = $urandom;
                end
            endcase
            step(agen_op_e'($urandom_range(0, 3)), 3'($urandom_range(0, 7)),
                 agen_op_e'($urandom_range(0, 3)), 3'($urandom_range(0, 7)),
                 we, wa, wd, 5'($urandom_range(0, 23)));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule